// File: doc/BRIEF.md
# Single-channel timer counter with deferred trigger

This block is one channel of a general-purpose timer. An up-counter advances on each valid edge of a count source. That source is either a tick from a free-running internal prescaler or a rising edge on one of three external clock inputs. When the count wraps from all-ones to zero, a sticky overflow flag is set. The flag stays set until software reads the status word. A level interrupt output combines that flag with a mask that software writes.

Software can restart the count with a trigger. A command bit or the `sync_in` input gives the same result. The trigger does not act at once. It waits for the next valid count edge, and at that edge the count becomes zero. A trigger issued while the channel is disabled is held and applied at the first valid edge after the channel is enabled again. A debug-halt input freezes counting unless software has set a keep-running bit.

A plain register port with four word addresses gives access to control, count, status and mask. Reads are combinational. Only a read of the status word has a side effect.

Top module: `tc_channel`

## Requirements
- R1: The count is CNT_W bits wide, resets to 0, and increases by exactly one on each valid edge of the selected source while the channel runs.
- R2: Control bits [3:1] select the count source. Values 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 clock cycles. Value 7 selects no source, and the count does not move.
- R3: Select values 4, 5 and 6 count rising edges of `ext_clk[0]`, `ext_clk[1]` and `ext_clk[2]`. Each input passes a two-flop synchronizer first. Edges on inputs that are not selected have no effect.
- R4: When a count edge takes the count from all-ones to 0, status bit 0 (address 2) becomes 1 and stays 1.
- R5: A read of address 2 clears status bit 0. If a wrap happens in the same cycle as that read, the bit stays 1.
- R6: `irq` is high exactly when status bit 0 and mask bit 0 (address 3) are both 1. It is a level output.
- R7: A trigger is a write to address 0 with bit 5 set, or `sync_in` high for one cycle. It leaves the count unchanged until the next valid edge, and that edge loads 0. A trigger never sets the overflow flag.
- R8: With control bit 0 (enable) clear, the count holds. A trigger issued while disabled is kept and loads 0 at the first valid edge after enable is set again.
- R9: While `dbg_halt` is high and control bit 4 (keep running) is clear, the count holds. With bit 4 set, the count keeps advancing.
- R10: Address 1 returns the current count at any time, and reading it does not disturb counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | NUM_EXT | Asynchronous external count clocks |
| sync_in | input | 1 | Trigger request, one cycle per trigger |
| dbg_halt | input | 1 | Debug halt indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address: 0 control, 1 count, 2 status, 3 mask |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, combinational from `addr` |
| irq | output | 1 | Level interrupt request |

## Verification
Every prescaler setting is swept by measuring the count change over a window of exactly a whole number of tick periods. That gives a known delta whatever the prescaler phase is, so a wrong divider tap shows up as a wrong delta. Each external input is pulsed together with the two inputs that are not selected, which tells correct source selection apart from cross-coupling. The trigger is exercised from both sources and while the channel is disabled, with the count read before the deferring edge and after it. A full wrap of a small 8-bit configuration is driven twice. The second time, the status read is placed in the exact cycle of the wrap, so that a clear-on-read which wins over the set is caught.

// File: rtl/tc_pkg.sv
// Shared definitions for the timer channel: register addresses and the
// control word layout. Assumes a word-addressed register port.
package tc_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_STATUS = 2'd2,
        REG_IMASK  = 2'd3
    } reg_addr_e;

    localparam int SEL_W  = 3;
    localparam int CTRL_W = 6;

    // Control word: bit0 enable, bits3:1 source select, bit4 keep in debug,
    // bit5 trigger request (write-only pulse).
    typedef struct packed {
        logic             trig_req;
        logic             keep_dbg;
        logic [SEL_W-1:0] clk_sel;
        logic             enable;
    } ctrl_t;
endpackage

// File: rtl/tc_clk_select.sv
// Count-source selector. Produces a one-cycle tick from either a free-running
// prescaler (divide by 2, 8, 32, 128 ...) or a synchronized rising edge of an
// external clock. Assumes external clocks are slower than half of clk.
module tc_clk_select #(
    parameter int NUM_EXT  = 3,
    parameter int PS_TAPS  = 4,
    parameter int SEL_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_clk,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    localparam int PS_W = 2 * PS_TAPS - 1;

    logic [PS_W-1:0]    psc_q;
    logic [PS_TAPS-1:0] tap;
    logic [NUM_EXT-1:0] rise;

    // Free-running prescaler counter.
    always_ff @(posedge clk) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_q + 1'b1;
    end

    for (genvar i = 0; i < PS_TAPS; i++) begin : g_tap
        assign tap[i] = &psc_q[2*i:0];
    end

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        logic s1_q, s2_q, s3_q;
        // Two-flop synchronizer plus a history flop for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= ext_clk[e];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign rise[e] = s2_q & ~s3_q;
    end

    // Route the selected source to the tick output.
    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < PS_TAPS; k++)
            if (int'(sel) == k) tick = tap[k];
        for (int k = 0; k < NUM_EXT; k++)
            if (int'(sel) == PS_TAPS + k) tick = rise[k];
    end

    assert_no_tick_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) >= PS_TAPS + NUM_EXT) |-> !tick);
endmodule

// File: rtl/tc_count_core.sv
// Counter core: advances on step, loads zero on a step while a trigger is
// pending or arriving, and flags wrap-around. Assumes step is a one-cycle enable.
module tc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             trig,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic pend_q;
    logic trig_eff;

    assign trig_eff = pend_q | trig;
    assign wrap     = step & ~trig_eff & (count == {CNT_W{1'b1}});

    // Count register and deferred-trigger memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            pend_q <= 1'b0;
        end else if (step) begin
            count  <= trig_eff ? '0 : count + 1'b1;
            pend_q <= 1'b0;
        end else if (trig) begin
            pend_q <= 1'b1;
        end
    end

    assert_hold_no_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> count == $past(count));
    assert_step_adds_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !trig_eff && count != {CNT_W{1'b1}}) |=> count == $past(count) + 1'b1);
    assert_trig_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && trig_eff) |=> count == '0);
endmodule

// File: rtl/tc_channel.sv
// Timer channel top: control/mask registers, run gating (enable, debug
// freeze), sticky overflow status with clear-on-read, and the level interrupt.
// Assumes CNT_W >= 6 so the control word fits the data bus.
module tc_channel #(
    parameter int CNT_W   = 16,
    parameter int NUM_EXT = 3,
    parameter int PS_TAPS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_clk,
    input  logic               sync_in,
    input  logic               dbg_halt,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   rdata,
    output logic               irq
);
    import tc_pkg::*;

    ctrl_t            ctrl_q, ctrl_w;
    logic             imask_q;
    logic             ovf_q;
    logic             tick, run, step, trig, wrap;
    logic             rd_status;
    logic [CNT_W-1:0] count;
    logic             unused_wdata;

    assign ctrl_w       = ctrl_t'(wdata[CTRL_W-1:0]);
    assign unused_wdata = ^wdata[CNT_W-1:CTRL_W];
    assign trig         = (wr_en && addr == REG_CTRL && ctrl_w.trig_req) || sync_in;
    assign run          = ctrl_q.enable && (!dbg_halt || ctrl_q.keep_dbg);
    assign step         = tick && run;
    assign rd_status    = rd_en && addr == REG_STATUS;

    tc_clk_select #(.NUM_EXT(NUM_EXT), .PS_TAPS(PS_TAPS), .SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .sel(ctrl_q.clk_sel), .tick(tick)
    );

    tc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .step(step), .trig(trig), .count(count), .wrap(wrap)
    );

    // Software-written control and interrupt mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            imask_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == REG_CTRL) begin
                ctrl_q          <= ctrl_w;
                ctrl_q.trig_req <= 1'b0;
            end
            if (addr == REG_IMASK) imask_q <= wdata[0];
        end
    end

    // Sticky overflow flag; a wrap wins over a same-cycle clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= wrap | (ovf_q & ~rd_status);
    end

    assign irq = ovf_q & imask_q;

    // Combinational register read mux.
    always_comb begin
        rdata = '0;
        unique case (reg_addr_e'(addr))
            REG_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
            REG_COUNT:  rdata = count;
            REG_STATUS: rdata[0] = ovf_q;
            REG_IMASK:  rdata[0] = imask_q;
        endcase
    end

    assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> count == '0);
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !wrap) |=> !ovf_q);
    assert_debug_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !ctrl_q.keep_dbg) |=> $stable(count));
    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.enable |=> $stable(count));
endmodule

// File: tb/tb_tc_channel.sv
module tb_tc_channel;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   ext_clk = '0;
    logic         sync_in = 1'b0;
    logic         dbg_halt = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [1:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    tc_channel #(.CNT_W(W), .NUM_EXT(3), .PS_TAPS(4)) dut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .sync_in(sync_in),
        .dbg_halt(dbg_halt), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 v = int'(rdata);
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic logic [W-1:0] cw(input int en, input int sel, input int keep, input int trg);
        return W'(en + (sel << 1) + (keep << 4) + (trg << 5));
    endfunction

    task automatic pulse(input int idx);
        @(negedge clk); ext_clk[idx] = 1'b1;
        repeat (2) @(negedge clk);
        ext_clk[idx] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Count change over exactly n cycles, sampled at negedges.
    task automatic span(input int n, output int delta);
        int c0;
        @(negedge clk); addr = 2'd1; #1 c0 = int'(rdata);
        repeat (n) @(negedge clk);
        #1 delta = (int'(rdata) - c0) & 255;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R1, R4, R6)
        rd(2'd1, v); check("R1 reset count", v, 0);
        rd(2'd2, v); check("R4 reset status", v, 0);
        check("R6 reset irq", int'(irq), 0);

        // Prescaler sweep (R2, R1, R10)
        for (int s = 0; s < 4; s++) begin
            wr(2'd0, cw(1, s, 0, 0));
            span(5 * (2 << (2 * s)), d);
            check($sformatf("R2 div sel %0d", s), d, 5);
        end
        wr(2'd0, cw(1, 7, 0, 0));
        span(300, d); check("R2 no source", d, 0);

        // External sources with cross-pulses (R3)
        for (int e = 0; e < 3; e++) begin
            int c0, c1;
            wr(2'd0, cw(1, 4 + e, 0, 0));
            rd(2'd1, c0);
            for (int p = 0; p < 3; p++) begin
                pulse(e);
                pulse((e + 1) % 3);
                pulse((e + 2) % 3);
            end
            repeat (3) @(negedge clk);
            rd(2'd1, c1);
            check($sformatf("R3 ext %0d", e), (c1 - c0) & 255, 3);
        end

        // Debug freeze (R9) and disable (R8)
        dbg_halt = 1'b1;
        wr(2'd0, cw(1, 0, 0, 0));
        span(40, d); check("R9 frozen", d, 0);
        wr(2'd0, cw(1, 0, 1, 0));
        span(40, d); check("R9 keep running", d, 20);
        dbg_halt = 1'b0;
        wr(2'd0, cw(0, 0, 0, 0));
        span(40, d); check("R8 disabled holds", d, 0);

        // Software trigger deferred (R7)
        wr(2'd0, cw(1, 4, 0, 0));
        rd(2'd2, v);
        pulse(0); pulse(0);
        repeat (3) @(negedge clk);
        rd(2'd1, v);
        wr(2'd0, cw(1, 4, 0, 1));
        repeat (10) @(negedge clk);
        rd(2'd1, d); check("R7 no immediate clear", d, v);
        pulse(0); repeat (3) @(negedge clk);
        rd(2'd1, v); check("R7 zero on edge", v, 0);
        pulse(0); repeat (3) @(negedge clk);
        rd(2'd1, v); check("R7 counts after", v, 1);
        rd(2'd2, v); check("R7 no overflow flag", v, 0);

        // SYNC trigger (R7)
        pulse(0); pulse(0); pulse(0); repeat (3) @(negedge clk);
        @(negedge clk); sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
        repeat (8) @(negedge clk);
        rd(2'd1, v); check("R7 sync deferred", v, 4);
        pulse(0); repeat (3) @(negedge clk);
        rd(2'd1, v); check("R7 sync zero", v, 0);

        // Trigger while disabled (R8)
        pulse(0); pulse(0); repeat (3) @(negedge clk);
        wr(2'd0, cw(0, 4, 0, 1));
        pulse(0); pulse(0); repeat (3) @(negedge clk);
        rd(2'd1, v); check("R8 held while disabled", v, 2);
        wr(2'd0, cw(1, 4, 0, 0));
        pulse(0); repeat (3) @(negedge clk);
        rd(2'd1, v); check("R8 pending applied", v, 0);

        // Overflow, mask, clear on read (R4, R5, R6)
        wr(2'd3, W'(1));
        for (int p = 0; p < 255; p++) pulse(0);
        repeat (3) @(negedge clk);
        rd(2'd1, v); check("R1 count 255", v, 255);
        check("R6 irq low before wrap", int'(irq), 0);
        pulse(0); repeat (3) @(negedge clk);
        rd(2'd1, v); check("R4 wrapped to 0", v, 0);
        check("R6 irq high", int'(irq), 1);
        wr(2'd3, W'(0));
        @(negedge clk); check("R6 masked", int'(irq), 0);
        wr(2'd3, W'(1));
        rd(2'd2, v); check("R4 status set", v, 1);
        @(negedge clk); check("R5 irq after read", int'(irq), 0);
        rd(2'd2, v); check("R5 cleared", v, 0);

        // Wrap in the same cycle as the status read (R5)
        for (int p = 0; p < 255; p++) pulse(0);
        repeat (3) @(negedge clk);
        @(negedge clk); ext_clk[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); rd_en = 1'b1; addr = 2'd2;
        @(negedge clk); rd_en = 1'b0; ext_clk[0] = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd1, v); check("R4 same-cycle wrap count", v, 0);
        rd(2'd2, v); check("R5 set wins over read", v, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule